// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

A synthesizable model of a small synchronous burst SRAM with flow-through reads. The data word has `LANES` byte lanes of `LANE_W` bits each (four lanes of eight bits by default). Address, write data and every control input are captured on the rising clock edge. One exception is the sleep input, which acts at once. The output enable also acts at once, and it only gates the read data.

A burst begins with a cycle where `load_n` is low. That cycle registers the external address and latches the decoded state of the three chip enables. The chip enables are not sampled again until the next load. After the load, a low `adv_n` steps the low two address bits by one at each edge. The step wraps modulo four, so a burst covers the four words of an aligned group in linear order. A high `adv_n` keeps the address and inserts a wait state. In the first cycle after a load, `adv_n` is treated as high, so that cycle reaches the loaded word.

Write enables are decoded for each lane. A global write stores the full word. Otherwise the byte-write enable qualifies the per-lane enables. A cycle that enables no lane is a read. The stored word at the current registered address is presented combinationally, with a valid flag, and the data bus reads zero while the flag is low.

Top module: `sbsram_core`

## Requirements
- R1: A cycle with `load_n` low registers `addr` as the burst address and performs no write, even when write enables are active. From the next cycle the output shows the word at that address.
- R2: The device is selected only if `ce_a_n`=0, `ce_b_n`=0 and `ce_c`=1 were sampled at the last load. While deselected, no write is stored and `rvalid` stays 0.
- R3: The chip enables are ignored in every cycle where `load_n` is high. The selection latched at the load holds for the rest of the burst.
- R4: With `gw_n` low, a write cycle stores all 32 bits, whatever the states of `bwe_n` and `bw_n`.
- R5: With `gw_n` high and `bwe_n` low, lane i is written only when `bw_n[i]` is 0. Lane 0 is bits 7:0, lane 1 bits 15:8, lane 2 bits 23:16 and lane 3 bits 31:24. With `gw_n` and `bwe_n` both high, nothing is written.
- R6: Outside the first cycle after a load, a low `adv_n` at an edge adds one to address bits 1:0 modulo 4 and leaves the upper bits unchanged. A high `adv_n` keeps the address (wait state). A write at an edge goes to the address after that edge's step.
- R7: In the first cycle after a load, `adv_n` is ignored, so the address does not move at that edge.
- R8: Reads are flow-through. `rdata` shows the word at the current registered address in the same cycle, including a word written at the previous edge.
- R9: `oe_n` high forces `rvalid` to 0 and `rdata` to 0 without waiting for a clock edge, and changes no internal state.
- R10: While `sleep` is high, all edges are ignored, the contents are kept and the outputs read 0 / invalid without waiting for a clock edge.
- R11: After reset (`rst_n` low, asynchronous), the device is deselected with `rvalid` 0.
- R12: `rvalid` is 1 only in a selected, non-sleeping cycle with `oe_n` low and no lane write-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Load a new burst address, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b_n | input | 1 | Second chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global full-word write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Sleep, asynchronous, active high |
| rdata | output | LANES*LANE_W | Flow-through read data, 0 when invalid |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest case to reach is a burst that crosses the modulo-four boundary after several lane-masked writes and a wait state, and is then read back. Proving this needs one continuous write burst from the middle of an aligned group. The stimulus table runs such a burst: it starts at word 5, wraps from 7 to 4, merges two partial byte writes into word 5, then reads the group back across the same wrap. Later vectors change the chip enables in the middle of a burst, load while deselected, raise sleep during a load with a global write, and check the ignored first advance. Directed steps then toggle the output enable and sleep between edges to show their immediate effect.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

   localparam int BURST_W = 2;

   function automatic logic chip_selected(input logic a_n, input logic b_n, input logic c);
      return !a_n && !b_n && c;
   endfunction

endpackage

// File: rtl/sbsram_addr_ctl.sv
module sbsram_addr_ctl #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              load_n,
   input  logic              adv_n,
   input  logic              sel_in,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] nxt_addr,
   output logic              sel_q
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic               first_q;
   logic [BURST_W-1:0] low_nxt;
   logic               step;

   if (ADDR_W <= BURST_W) begin : g_bad_width
      $error("ADDR_W must exceed BURST_W");
   end

   assign step     = !adv_n && !first_q;
   assign low_nxt  = cur_addr[BURST_W-1:0] + BURST_W'(step);
   assign nxt_addr = {cur_addr[ADDR_W-1:BURST_W], low_nxt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         sel_q    <= 1'b0;
         first_q  <= 1'b0;
      end else if (!sleep) begin
         if (!load_n) begin
            cur_addr <= addr;
            sel_q    <= sel_in;
            first_q  <= 1'b1;
         end else begin
            cur_addr <= nxt_addr;
            first_q  <= 1'b0;
         end
      end
   end

   assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n || sleep) |=> $stable(sel_q));

   assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_n |=> $stable(cur_addr[ADDR_W-1:ADDR_W-HI_W]));

   assert_first_no_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (first_q && load_n) |=> $stable(cur_addr));

   assert_sleep_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(cur_addr) && $stable(sel_q)));

endmodule

// File: rtl/sbsram_wen_dec.sv
module sbsram_wen_dec #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] lane_we
);
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_we[i] = !gw_n || (!bwe_n && !bw_n[i]);
   end

   assert_global_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !gw_n |-> (&lane_we));

   assert_byte_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gw_n && bwe_n) |-> (lane_we == '0));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_we[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
      end

      assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
   end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_n,
   input  logic                    ce_a_n,
   input  logic                    ce_b_n,
   input  logic                    ce_c,
   input  logic                    adv_n,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    oe_n,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rvalid
);
   localparam int DATA_W = LANES * LANE_W;

   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] nxt_addr;
   logic              sel_q;
   logic [LANES-1:0]  lane_we;
   logic              any_we;
   logic              wr_go;
   logic [DATA_W-1:0] arr_rd;

   sbsram_addr_ctl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep   (sleep),
      .load_n  (load_n),
      .adv_n   (adv_n),
      .sel_in  (chip_selected(ce_a_n, ce_b_n, ce_c)),
      .addr    (addr),
      .cur_addr(cur_addr),
      .nxt_addr(nxt_addr),
      .sel_q   (sel_q)
   );

   sbsram_wen_dec #(.LANES(LANES)) u_wen (
      .clk    (clk),
      .rst_n  (rst_n),
      .gw_n   (gw_n),
      .bwe_n  (bwe_n),
      .bw_n   (bw_n),
      .lane_we(lane_we)
   );

   assign any_we = |lane_we;
   assign wr_go  = !sleep && load_n && sel_q && any_we;

   sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk    (clk),
      .we     (wr_go),
      .lane_we(lane_we),
      .waddr  (nxt_addr),
      .wdata  (wdata),
      .raddr  (cur_addr),
      .rdata  (arr_rd)
   );

   assign rvalid = sel_q && !oe_n && !sleep && !any_we;
   assign rdata  = rvalid ? arr_rd : '0;

   assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!rvalid && rdata == '0));

   assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (!rvalid && rdata == '0));

   assert_read_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |-> (gw_n && (bwe_n || (&bw_n))));

endmodule

// File: tb/sbsram_core_bench.sv
module sbsram_core_bench;

   typedef struct packed {
      logic        load_n;
      logic [2:0]  ce;      // {ce_a_n, ce_b_n, ce_c}
      logic        adv_n;
      logic        gw_n;
      logic        bwe_n;
      logic [3:0]  bw_n;
      logic [5:0]  addr;
      logic [31:0] wdata;
      logic        oe_n;
      logic        sleep;
      logic        ev;
      logic [31:0] ed;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 25;
   localparam logic [2:0] S = 3'b001;
   localparam logic [2:0] D = 3'b000;

   // Expected values are the outputs during the vector's cycle, before its edge.
   localparam vec_t TBL [NV] = '{
      {1'b0,S,1'b1,1'b1,1'b1,4'hF,6'h05,32'h0,       1'b0,1'b0,1'b0,32'h0,        8'd1},  // R1 load 5
      {1'b1,S,1'b1,1'b0,1'b1,4'hF,6'h00,32'h11111111,1'b0,1'b0,1'b0,32'h0,        8'd4},  // R4 write 5
      {1'b1,S,1'b0,1'b0,1'b1,4'hF,6'h00,32'h22222222,1'b0,1'b0,1'b0,32'h0,        8'd6},  // R6 write 6
      {1'b1,S,1'b0,1'b0,1'b0,4'hF,6'h00,32'h44444444,1'b0,1'b0,1'b0,32'h0,        8'd4},  // R4 override, 7
      {1'b1,S,1'b0,1'b0,1'b1,4'hF,6'h00,32'h55555555,1'b0,1'b0,1'b0,32'h0,        8'd6},  // R6 wrap to 4
      {1'b1,S,1'b0,1'b1,1'b0,4'hE,6'h00,32'h000000AB,1'b0,1'b0,1'b0,32'h0,        8'd5},  // R5 lane 0 of 5
      {1'b1,S,1'b1,1'b1,1'b0,4'h5,6'h00,32'hCC00DD00,1'b0,1'b0,1'b0,32'h0,        8'd5},  // R5 lanes 1,3
      {1'b1,S,1'b1,1'b1,1'b1,4'h0,6'h00,32'h0,       1'b0,1'b0,1'b1,32'hCC11DDAB, 8'd5},  // R5 R8 merged
      {1'b1,S,1'b0,1'b1,1'b0,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'hCC11DDAB, 8'd12}, // R12
      {1'b1,S,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h22222222, 8'd6},
      {1'b1,S,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h44444444, 8'd6},
      {1'b1,S,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b1,1'b0,1'b0,32'h0,        8'd9},  // R9
      {1'b1,S,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h55555555, 8'd6},  // R6 wrapped
      {1'b1,D,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h55555555, 8'd3},  // R3
      {1'b0,D,1'b1,1'b1,1'b1,4'hF,6'h06,32'h0,       1'b0,1'b0,1'b1,32'h55555555, 8'd3},  // R3 load desel
      {1'b1,S,1'b1,1'b0,1'b1,4'hF,6'h00,32'hDEADBEEF,1'b0,1'b0,1'b0,32'h0,        8'd2},  // R2
      {1'b1,S,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b0,32'h0,        8'd2},  // R2
      {1'b0,S,1'b1,1'b1,1'b1,4'hF,6'h06,32'h0,       1'b0,1'b0,1'b0,32'h0,        8'd1},  // R1
      {1'b1,S,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h22222222, 8'd2},  // R2 not written
      {1'b1,S,1'b0,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h22222222, 8'd7},  // R7
      {1'b1,S,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h44444444, 8'd7},
      {1'b0,S,1'b0,1'b0,1'b1,4'hF,6'h04,32'h99999999,1'b0,1'b1,1'b0,32'h0,        8'd10}, // R10
      {1'b1,S,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h44444444, 8'd10},
      {1'b0,S,1'b1,1'b0,1'b1,4'hF,6'h07,32'h77777777,1'b0,1'b0,1'b0,32'h0,        8'd1},  // R1 no write
      {1'b1,S,1'b1,1'b1,1'b1,4'hF,6'h00,32'h0,       1'b0,1'b0,1'b1,32'h44444444, 8'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_n = 1'b1, ce_a_n = 1'b1, ce_b_n = 1'b1, ce_c = 1'b0;
   logic        adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
   logic [3:0]  bw_n = 4'hF;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rvalid;
   int          checks = 0;
   int          fails = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   sbsram_core u_sbsram_core (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n),
      .ce_c(ce_c), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
      .addr(addr), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
      .rdata(rdata), .rvalid(rvalid)
   );

   task automatic check(input string req, input logic ev, input logic [31:0] ed);
      checks++;
      if (rvalid !== ev || rdata !== ed) begin
         fails++;
         $display("FAIL %s: rvalid=%0b rdata=%h, expected rvalid=%0b rdata=%h",
                  req, rvalid, rdata, ev, ed);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      // R11: reset state
      #3;
      check("R11", 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 check("R11", 1'b0, 32'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         load_n = TBL[i].load_n;
         {ce_a_n, ce_b_n, ce_c} = TBL[i].ce;
         adv_n = TBL[i].adv_n;
         gw_n  = TBL[i].gw_n;
         bwe_n = TBL[i].bwe_n;
         bw_n  = TBL[i].bw_n;
         addr  = TBL[i].addr;
         wdata = TBL[i].wdata;
         oe_n  = TBL[i].oe_n;
         sleep = TBL[i].sleep;
         #1 check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].ev, TBL[i].ed);
      end

      // Address 7 is being read (value 44444444) with oe_n low.
      @(negedge clk);
      load_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; oe_n = 1'b0; sleep = 1'b0;
      #1 check("R8", 1'b1, 32'h44444444);
      #1 oe_n = 1'b1;
      #1 check("R9 async", 1'b0, 32'h0);
      #1 oe_n = 1'b0;
      #1 check("R9 no state change", 1'b1, 32'h44444444);
      #1 sleep = 1'b1;
      #1 check("R10 async", 1'b0, 32'h0);
      @(negedge clk);
      sleep = 1'b0;
      #1 check("R10 contents kept", 1'b1, 32'h44444444);
      #1 rst_n = 1'b0;
      #1 check("R11 async reset", 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1 check("R11 after release", 1'b0, 32'h0);

      done = 1'b1;
      finish_run();
   end

endmodule